// File: doc/BRIEF.md
# Message Block Packer for a Hash Core

This block sits in front of a hash compression core. It takes a message one 32-bit word at a time and collects the words into 512-bit blocks of sixteen words. Words can come from a CPU-driven register path or from a DMA request path. Both paths use the same word port. When a block is complete, the block is handed to the core over a valid/ready handshake. While the core has not yet taken the block, the word input is stalled.

Software marks the end of a message with a digest command. Before that command, it programs a 5-bit field that gives the number of valid bits in the final word. The digest command closes the partial block and passes it on with three pieces of information: a final-block flag, the number of words in the block, and the captured valid-bit count. The padding stage downstream uses these to place the terminating 1 bit. An init command clears all state so that a new message can start. A DMA enable bit turns itself off when the DMA engine signals that the transfer has ended.

Top module: `msg_block_packer`

## Requirements
- R1: Word k of a block (k = 0 for the first word accepted into that block) appears on bits [32k+31:32k] of blkData. Any word position that the block does not fill reads as zero.
- R2: In the clock cycle after the sixteenth word of a block is accepted, blkValid and busy are 1, blkLast is 0, blkWords is 16 and blkLastBits is 0.
- R3: wordCount gives the number of words currently held. It rises by one for each accepted word, never exceeds 16, and is 0 in the cycle after a block handshake (blkValid and blkReady both high at a clock edge).
- R4: While a block is offered and not yet taken, wordReady is 0, offered words are neither stored nor counted, and blkData, blkWords and blkLast hold steady.
- R5: A digest command during filling presents, in the next cycle, a final block: blkLast is 1 and blkWords counts the words held, including a word accepted in the same cycle as the command.
- R6: lastBitsIn is written with lastBitsWe. A value of 0 means all 32 bits of the final word are valid; a value n from 1 to 31 means only bits [n-1:0] are valid. The value held when the digest takes effect appears on blkLastBits of the final block. A later write does not change it. Non-final blocks carry 0.
- R7: If a digest command arrives while a full block is still being offered, that block keeps blkLast = 0. In the cycle after its handshake, an empty final block is offered with blkLast = 1, blkWords = 0 and the captured valid-bit count.
- R8: After the final block's handshake, wordReady stays 0, wordCount stays 0, and a further digest command produces no block, until init.
- R9: In the cycle after init, wordCount is 0, blkValid is 0, the valid-bit field is 0, dmaEnable is 0 and wordReady is 1. A word offered in the same cycle as init is dropped. Init takes priority over every other input.
- R10: dmaStart sets dmaEnable. dmaEnable is 0 in the cycle after dmaEnd. dmaReq equals dmaEnable AND wordReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initCmd | input | 1 | Pulse that starts a new message |
| wordValid | input | 1 | A message word is offered |
| wordData | input | 32 | Message word |
| wordReady | output | 1 | The word is taken at this edge if wordValid is high |
| wordCount | output | 5 | Number of words held |
| lastBitsWe | input | 1 | Write strobe for the final-word valid-bit field |
| lastBitsIn | input | 5 | Final-word valid-bit count (0 means all 32 bits are valid) |
| digestCmd | input | 1 | Pulse that closes the message |
| dmaStart | input | 1 | Sets the DMA enable |
| dmaEnd | input | 1 | Signals that the DMA transfer has ended; clears the enable |
| dmaEnable | output | 1 | DMA enable state |
| dmaReq | output | 1 | Request to the DMA engine for one more word |
| busy | output | 1 | A block is waiting for the core |
| blkValid | output | 1 | A block is offered to the core |
| blkReady | input | 1 | The core accepts the block |
| blkData | output | 512 | Block contents, word 0 in the low bits |
| blkLast | output | 1 | The offered block is the final one of the message |
| blkWords | output | 5 | Number of message words in the offered block |
| blkLastBits | output | 5 | Valid-bit count of the final word (final block only) |

## Verification
Two situations are hard to reach from the ports. The first is a digest command that arrives while a full block is still stalled in front of the core. The bench fills sixteen words, holds blkReady low, issues the digest, and only then accepts the block, so that it can watch the empty final block that follows. The second is a stalled block followed by stalled writes. The bench keeps wordValid high for several cycles while the core does not respond, and checks that the count and data do not move. Partial final blocks are swept over every length from 0 to 15 words, each with its own valid-bit value. There are also separate runs for a word and a digest arriving in the same cycle, and for an init that coincides with a write.

// File: rtl/msg_pack_pkg.sv
package msg_pack_pkg;

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SPENT = 2'd2
  } fillState_t;

  typedef struct packed {
    logic wrEn;
    logic clrAll;
  } dpStrobe_t;

endpackage

// File: rtl/msg_pack_dpath.sv
module msg_pack_dpath
  import msg_pack_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 16,
  parameter int IDX_W       = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic [WORD_W-1:0]             wordData,
  output logic [BLOCK_WORDS*WORD_W-1:0] blkData
);

  for (genvar i = 0; i < BLOCK_WORDS; i++) begin : g_slot
    logic [WORD_W-1:0] slotQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (strobe.clrAll) begin
        slotQ <= '0;
      end else if (strobe.wrEn && (wrIdx == IDX_W'(i))) begin
        slotQ <= wordData;
      end
    end

    assign blkData[i*WORD_W +: WORD_W] = slotQ;
  end

endmodule

// File: rtl/msg_pack_ctrl.sv
module msg_pack_ctrl
  import msg_pack_pkg::*;
#(
  parameter int BLOCK_WORDS = 16,
  parameter int CNT_W       = 5,
  parameter int IDX_W       = 4,
  parameter int VB_W        = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initCmd,
  input  logic             digestCmd,
  input  logic             wordValid,
  output logic             wordReady,
  input  logic             lastBitsWe,
  input  logic [VB_W-1:0]  lastBitsIn,
  input  logic             dmaStart,
  input  logic             dmaEnd,
  output logic             dmaEnable,
  input  logic             blkReady,
  output logic             blkValid,
  output logic             blkLast,
  output logic [CNT_W-1:0] blkWords,
  output logic [VB_W-1:0]  blkLastBits,
  output logic [CNT_W-1:0] wordCount,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] wrIdx
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLOCK_WORDS);

  fillState_t       stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] wordsQ;
  logic [VB_W-1:0]  bitsQ;
  logic [VB_W-1:0]  vbQ;
  logic             lastQ;
  logic             pendQ;
  logic             dmaQ;

  logic             accept;
  logic             handshake;
  logic [CNT_W-1:0] cntInc;

  always_comb begin
    wordReady      = (stateQ == ST_FILL);
    accept         = wordValid && wordReady && !initCmd;
    handshake      = (stateQ == ST_HOLD) && blkReady && !initCmd;
    cntInc         = cntQ + CNT_W'(accept);
    strobe.wrEn    = accept;
    strobe.clrAll  = initCmd || handshake;
    wrIdx          = cntQ[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_FILL;
      cntQ   <= '0;
      wordsQ <= '0;
      bitsQ  <= '0;
      vbQ    <= '0;
      lastQ  <= 1'b0;
      pendQ  <= 1'b0;
      dmaQ   <= 1'b0;
    end else if (initCmd) begin
      stateQ <= ST_FILL;
      cntQ   <= '0;
      wordsQ <= '0;
      bitsQ  <= '0;
      vbQ    <= '0;
      lastQ  <= 1'b0;
      pendQ  <= 1'b0;
      dmaQ   <= 1'b0;
    end else begin
      if (lastBitsWe) begin
        vbQ <= lastBitsIn;
      end
      if (dmaEnd) begin
        dmaQ <= 1'b0;
      end else if (dmaStart) begin
        dmaQ <= 1'b1;
      end

      case (stateQ)
        ST_FILL: begin
          cntQ <= cntInc;
          if (digestCmd) begin
            stateQ <= ST_HOLD;
            lastQ  <= 1'b1;
            wordsQ <= cntInc;
            bitsQ  <= vbQ;
          end else if (cntInc == FULL_CNT) begin
            stateQ <= ST_HOLD;
            lastQ  <= 1'b0;
            wordsQ <= FULL_CNT;
            bitsQ  <= '0;
          end
        end
        ST_HOLD: begin
          if (digestCmd && !lastQ) begin
            pendQ <= 1'b1;
          end
          if (blkReady) begin
            cntQ <= '0;
            if (lastQ) begin
              stateQ <= ST_SPENT;
              lastQ  <= 1'b0;
            end else if (pendQ || digestCmd) begin
              stateQ <= ST_HOLD;
              lastQ  <= 1'b1;
              wordsQ <= '0;
              bitsQ  <= vbQ;
              pendQ  <= 1'b0;
            end else begin
              stateQ <= ST_FILL;
            end
          end
        end
        default: begin
          cntQ <= '0;
        end
      endcase
    end
  end

  always_comb begin
    blkValid    = (stateQ == ST_HOLD);
    blkLast     = blkValid && lastQ;
    blkWords    = blkValid ? wordsQ : '0;
    blkLastBits = blkValid ? bitsQ : '0;
    wordCount   = cntQ;
    dmaEnable   = dmaQ;
  end

endmodule

// File: rtl/msg_block_packer.sv
module msg_block_packer
  import msg_pack_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 16,
  localparam int CNT_W      = $clog2(BLOCK_WORDS + 1),
  localparam int IDX_W      = $clog2(BLOCK_WORDS),
  localparam int VB_W       = $clog2(WORD_W),
  localparam int BLK_W      = BLOCK_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initCmd,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              wordReady,
  output logic [CNT_W-1:0]  wordCount,
  input  logic              lastBitsWe,
  input  logic [VB_W-1:0]   lastBitsIn,
  input  logic              digestCmd,
  input  logic              dmaStart,
  input  logic              dmaEnd,
  output logic              dmaEnable,
  output logic              dmaReq,
  output logic              busy,
  output logic              blkValid,
  input  logic              blkReady,
  output logic [BLK_W-1:0]  blkData,
  output logic              blkLast,
  output logic [CNT_W-1:0]  blkWords,
  output logic [VB_W-1:0]   blkLastBits
);

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] wrIdx;

  msg_pack_ctrl #(
    .BLOCK_WORDS(BLOCK_WORDS),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W),
    .VB_W       (VB_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .initCmd    (initCmd),
    .digestCmd  (digestCmd),
    .wordValid  (wordValid),
    .wordReady  (wordReady),
    .lastBitsWe (lastBitsWe),
    .lastBitsIn (lastBitsIn),
    .dmaStart   (dmaStart),
    .dmaEnd     (dmaEnd),
    .dmaEnable  (dmaEnable),
    .blkReady   (blkReady),
    .blkValid   (blkValid),
    .blkLast    (blkLast),
    .blkWords   (blkWords),
    .blkLastBits(blkLastBits),
    .wordCount  (wordCount),
    .strobe     (strobe),
    .wrIdx      (wrIdx)
  );

  msg_pack_dpath #(
    .WORD_W     (WORD_W),
    .BLOCK_WORDS(BLOCK_WORDS),
    .IDX_W      (IDX_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrIdx   (wrIdx),
    .wordData(wordData),
    .blkData (blkData)
  );

  assign busy   = blkValid;
  assign dmaReq = dmaEnable && wordReady;

endmodule

// File: rtl/msg_block_packer_chk.sv
module msg_block_packer_chk #(
  parameter int WORD_W      = 32,
  parameter int BLOCK_WORDS = 16,
  parameter int CNT_W       = 5
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          initCmd,
  input logic                          digestCmd,
  input logic                          wordValid,
  input logic                          wordReady,
  input logic [CNT_W-1:0]              wordCount,
  input logic                          dmaEnd,
  input logic                          dmaEnable,
  input logic                          blkValid,
  input logic                          blkReady,
  input logic                          blkLast,
  input logic [CNT_W-1:0]              blkWords,
  input logic [BLOCK_WORDS*WORD_W-1:0] blkData
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLOCK_WORDS);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordCount <= FULL_CNT);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordReady && !initCmd && !digestCmd && (wordCount < FULL_CNT - 1'b1))
    |=> (wordCount == $past(wordCount) + 1'b1));

  assert_full_block_R2: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && !blkLast) |-> (blkWords == FULL_CNT));

  assert_no_input_while_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    blkValid |-> !wordReady);

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && !blkReady && !initCmd)
    |=> (blkValid && $stable(blkData) && $stable(blkWords) && $stable(blkLast)));

  assert_spent_after_final_R8: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && blkReady && blkLast && !initCmd) |=> (!wordReady && !blkValid));

  assert_init_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    initCmd |=> ((wordCount == '0) && !blkValid && !dmaEnable && wordReady));

  assert_dma_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    dmaEnd |=> !dmaEnable);

endmodule

bind msg_block_packer msg_block_packer_chk #(
  .WORD_W     (WORD_W),
  .BLOCK_WORDS(BLOCK_WORDS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .initCmd  (initCmd),
  .digestCmd(digestCmd),
  .wordValid(wordValid),
  .wordReady(wordReady),
  .wordCount(wordCount),
  .dmaEnd   (dmaEnd),
  .dmaEnable(dmaEnable),
  .blkValid (blkValid),
  .blkReady (blkReady),
  .blkLast  (blkLast),
  .blkWords (blkWords),
  .blkData  (blkData)
);

// File: tb/tb_msg_block_packer.sv
`timescale 1ns/1ps
module tb_msg_block_packer;

  localparam int WW = 32;
  localparam int BW = 16;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          initCmd = 1'b0;
  logic          wordValid = 1'b0;
  logic [WW-1:0] wordData = '0;
  logic          wordReady;
  logic [CW-1:0] wordCount;
  logic          lastBitsWe = 1'b0;
  logic [4:0]    lastBitsIn = '0;
  logic          digestCmd = 1'b0;
  logic          dmaStart = 1'b0;
  logic          dmaEnd = 1'b0;
  logic          dmaEnable;
  logic          dmaReq;
  logic          busy;
  logic          blkValid;
  logic          blkReady = 1'b0;
  logic [BW*WW-1:0] blkData;
  logic          blkLast;
  logic [CW-1:0] blkWords;
  logic [4:0]    blkLastBits;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  msg_block_packer #(.WORD_W(WW), .BLOCK_WORDS(BW)) dut (
    .clk(clk), .rstN(rstN), .initCmd(initCmd), .wordValid(wordValid),
    .wordData(wordData), .wordReady(wordReady), .wordCount(wordCount),
    .lastBitsWe(lastBitsWe), .lastBitsIn(lastBitsIn), .digestCmd(digestCmd),
    .dmaStart(dmaStart), .dmaEnd(dmaEnd), .dmaEnable(dmaEnable), .dmaReq(dmaReq),
    .busy(busy), .blkValid(blkValid), .blkReady(blkReady), .blkData(blkData),
    .blkLast(blkLast), .blkWords(blkWords), .blkLastBits(blkLastBits)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input int n, input int k);
    return {8'hA5, 8'(n), 8'(k), 8'h3C};
  endfunction

  task automatic push(input logic [31:0] d);
    wordValid = 1'b1; wordData = d;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic pulseInit();
    initCmd = 1'b1; @(negedge clk); initCmd = 1'b0;
  endtask

  task automatic pulseDigest();
    digestCmd = 1'b1; @(negedge clk); digestCmd = 1'b0;
  endtask

  task automatic setBits(input logic [4:0] v);
    lastBitsWe = 1'b1; lastBitsIn = v; @(negedge clk); lastBitsWe = 1'b0;
  endtask

  task automatic takeBlock();
    blkReady = 1'b1; @(negedge clk); blkReady = 1'b0;
  endtask

  task automatic checkData(input string tag, input int n, input int tagN);
    for (int k = 0; k < BW; k++) begin
      chk(tag, blkData[k*WW +: WW], (k < n) ? mkWord(tagN, k) : 32'h0);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset count", 32'(wordCount), 0);
    chk("R9 reset blkValid", 32'(blkValid), 0);
    chk("R9 reset wordReady", 32'(wordReady), 1);
    chk("R9 reset dmaEnable", 32'(dmaEnable), 0);

    // R5 R6 R1 R8: sweep of every partial length
    for (int n = 0; n < BW; n++) begin
      logic [4:0] vb;
      vb = 5'((n * 7 + 1) % 32);
      pulseInit();
      setBits(vb);
      for (int k = 0; k < n; k++) push(mkWord(n, k));
      chk("R3 count after fill", 32'(wordCount), 32'(n));
      pulseDigest();
      chk("R5 final valid", 32'(blkValid), 1);
      chk("R5 final last", 32'(blkLast), 1);
      chk("R5 final words", 32'(blkWords), 32'(n));
      chk("R6 final bits", 32'(blkLastBits), 32'(vb));
      chk("R4 busy while offered", 32'(busy), 1);
      chk("R4 wordReady low", 32'(wordReady), 0);
      checkData("R1 partial data", n, n);
      setBits(5'(vb + 5'd3));
      chk("R6 bits unchanged", 32'(blkLastBits), 32'(vb));
      chk("R4 words stable", 32'(blkWords), 32'(n));
      takeBlock();
      chk("R8 no block after final", 32'(blkValid), 0);
      chk("R3 count zero after take", 32'(wordCount), 0);
      chk("R8 wordReady low spent", 32'(wordReady), 0);
      pulseDigest();
      chk("R8 digest ignored", 32'(blkValid), 0);
      push(32'hDEAD_BEEF);
      chk("R8 word ignored", 32'(wordCount), 0);
    end

    // R2 R4 R7: full block with a digest arriving while it is held
    pulseInit();
    setBits(5'd9);
    for (int k = 0; k < BW; k++) push(mkWord(16, k));
    chk("R2 full valid", 32'(blkValid), 1);
    chk("R2 full last", 32'(blkLast), 0);
    chk("R2 full words", 32'(blkWords), 16);
    chk("R2 full bits", 32'(blkLastBits), 0);
    chk("R2 busy", 32'(busy), 1);
    chk("R2 wordReady", 32'(wordReady), 0);
    checkData("R1 full data", BW, 16);
    wordValid = 1'b1; wordData = 32'h1234_5678;
    repeat (3) @(negedge clk);
    wordValid = 1'b0;
    chk("R4 stalled count", 32'(wordCount), 16);
    checkData("R4 stalled data", BW, 16);
    pulseDigest();
    chk("R7 held block not last", 32'(blkLast), 0);
    takeBlock();
    chk("R7 empty final valid", 32'(blkValid), 1);
    chk("R7 empty final last", 32'(blkLast), 1);
    chk("R7 empty final words", 32'(blkWords), 0);
    chk("R7 empty final bits", 32'(blkLastBits), 9);
    chk("R7 count zero", 32'(wordCount), 0);
    checkData("R7 empty data", 0, 0);
    takeBlock();
    chk("R8 spent after empty final", 32'(wordReady), 0);

    // R3 R1: full block then continue into a second block
    pulseInit();
    for (int k = 0; k < BW; k++) push(mkWord(16, k));
    takeBlock();
    chk("R3 count zero after take", 32'(wordCount), 0);
    chk("R3 ready after take", 32'(wordReady), 1);
    chk("R3 no block", 32'(blkValid), 0);
    push(mkWord(17, 0));
    push(mkWord(17, 1));
    pulseDigest();
    chk("R5 second block words", 32'(blkWords), 2);
    checkData("R1 second block data", 2, 17);
    takeBlock();

    // R5: word and digest in the same cycle
    pulseInit();
    for (int k = 0; k < 3; k++) push(mkWord(20, k));
    wordValid = 1'b1; wordData = mkWord(20, 3); digestCmd = 1'b1;
    @(negedge clk);
    wordValid = 1'b0; digestCmd = 1'b0;
    chk("R5 same-cycle words", 32'(blkWords), 4);
    checkData("R5 same-cycle data", 4, 20);
    takeBlock();

    // R5: fifteen words plus a same-cycle word fill a final block
    pulseInit();
    for (int k = 0; k < BW - 1; k++) push(mkWord(21, k));
    wordValid = 1'b1; wordData = mkWord(21, BW - 1); digestCmd = 1'b1;
    @(negedge clk);
    wordValid = 1'b0; digestCmd = 1'b0;
    chk("R5 sixteen-word final last", 32'(blkLast), 1);
    chk("R5 sixteen-word final words", 32'(blkWords), 16);
    takeBlock();

    // R9: init mid-block, with a word in the same cycle
    pulseInit();
    setBits(5'd7);
    for (int k = 0; k < 5; k++) push(mkWord(29, k));
    wordValid = 1'b1; wordData = 32'hBAD0_0001; initCmd = 1'b1;
    @(negedge clk);
    wordValid = 1'b0; initCmd = 1'b0;
    chk("R9 init count", 32'(wordCount), 0);
    chk("R9 init blkValid", 32'(blkValid), 0);
    chk("R9 init ready", 32'(wordReady), 1);
    push(mkWord(30, 0));
    pulseDigest();
    chk("R9 bits cleared", 32'(blkLastBits), 0);
    chk("R9 words after init", 32'(blkWords), 1);
    checkData("R9 data after init", 1, 30);
    pulseInit();
    chk("R9 init drops held block", 32'(blkValid), 0);

    // R10: DMA enable and request
    dmaStart = 1'b1; @(negedge clk); dmaStart = 1'b0;
    chk("R10 dma enabled", 32'(dmaEnable), 1);
    chk("R10 dma request", 32'(dmaReq), 1);
    for (int k = 0; k < BW; k++) push(mkWord(40, k));
    chk("R10 request low while held", 32'(dmaReq), 0);
    chk("R10 enable kept", 32'(dmaEnable), 1);
    dmaEnd = 1'b1; @(negedge clk); dmaEnd = 1'b0;
    chk("R10 enable cleared", 32'(dmaEnable), 0);
    takeBlock();
    chk("R10 no request when off", 32'(dmaReq), 0);
    dmaStart = 1'b1; @(negedge clk); dmaStart = 1'b0;
    pulseInit();
    chk("R9 init clears dma", 32'(dmaEnable), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule